// File: doc/BRIEF.md
# LIN Slave Power-Mode Controller

This block is the operating-mode sequencer of a LIN slave companion chip. It takes already-synchronised pin levels (EN, TX), a LIN-dominant indication from the receiver, a one-cycle strobe from the temporary-shutdown control bit, and comparator flags for supply brown-out, thermal shutdown, over-temperature warning and VCC undervoltage. It then moves the chip between initialisation, normal operation, a low-power mode (standby, or sleep when the parameter selects it), a timed temporary shutdown and thermal shutdown. A 128 kHz tick, given as a one-cycle pulse on the system clock, drives every timer.

The outputs enable the regulator, the transceiver and the window watchdog. The block also drives the microcontroller reset, clears the mode and diagnostic registers, and gives one-cycle strobes that set the remote-wake, temporary-shutdown, TX-timeout and over-temperature-warning flags. It also contains the TX dominant-timeout guard, which releases the LIN driver to recessive when TX stays low too long during normal operation.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `supplyLow` is high, the next cycle shows `modeOut` = 0 (init), `rstOutN` low and `clearRegs` high, whatever the previous mode. From init the block goes to normal (`modeOut` = 1) in the first cycle in which neither `supplyLow` nor `hotShut` is high.
- R2: In normal mode with `rstOutN` high, a falling EN while TX is high moves to arm (`modeOut` = 2). If EN stays low and TX stays high for TRIG_TICKS ticks, the block moves to enter (3). After ENTER_TICKS further ticks it moves to low-power (4). TX going low or EN going high during arm returns to normal.
- R3: In low-power mode, LIN dominant held for WAKE_TICKS consecutive ticks moves to exit (5) and gives one `wakeSet` pulse. A recessive level restarts the count.
- R4: A `tmpShutWr` pulse in normal or arm mode moves to temporary shutdown (6) with one `tmpShutSet` pulse. `regEn` is low in that mode. After TMPSHUT_TICKS ticks the block returns to normal, and LIN dominant has no effect meanwhile.
- R5: `hotShut` high without `supplyLow` forces thermal shutdown (7) from any mode, with `regEn`, `xcvrEn` and `wdEn` low. When it clears, the block passes through init (register clear) into normal.
- R6: An EN rising edge in low-power mode moves to exit. Exit lasts EXIT_TICKS ticks, then the block goes to normal.
- R7: In normal mode, TX low for TXTO_TICKS ticks sets `drvRelease` together with one `txToSet` pulse. `drvRelease` drops on the edge after TX is seen high.
- R8: `rstOutN` goes low once `vccLow` has been high for more than SPIKE_TICKS ticks. It goes high once `vccLow` has been low for RES_TICKS ticks. A shorter low pulse on VCC leaves the reset output unchanged.
- R9: A rising `warnTemp` gives one `warnSet` pulse and leaves the mode unchanged.
- R10: While `rstOutN` is low in normal mode, the block ignores `tmpShutWr` and EN falls. When a `tmpShutWr` pulse and an EN fall occur in the same cycle, temporary shutdown wins.
- R11: The TX timeout counts only in normal mode. TX held low through low-power mode gives no release. The count starts from zero on return to normal.
- R12: `xcvrEn` is high only in normal, arm and enter modes. `wdEn` is high in those modes only while `rstOutN` is high. `regEn` is low in init, temporary shutdown and thermal shutdown, and also in low-power mode when SLEEP_OPT is 1.
- R13: A `wdFault` pulse while `wdEn` is high pulls `rstOutN` low. The reset then releases after RES_TICKS ticks of good VCC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | One-cycle 128 kHz timebase pulse |
| supplyLow | input | 1 | Battery brown-out comparator |
| hotShut | input | 1 | Junction above shutdown threshold (hysteresis external) |
| warnTemp | input | 1 | Over-temperature warning comparator |
| vccLow | input | 1 | VCC below undervoltage threshold |
| enPin | input | 1 | Synchronised EN level |
| txPin | input | 1 | Synchronised TX level (low = dominant) |
| linDom | input | 1 | LIN bus seen dominant |
| tmpShutWr | input | 1 | Strobe: 1 written to the temporary-shutdown bit |
| wdFault | input | 1 | Window watchdog missed-window strobe |
| modeOut | output | 3 | Current mode code (0 init … 7 thermal) |
| regEn | output | 1 | Regulator enable |
| xcvrEn | output | 1 | Transceiver enable |
| wdEn | output | 1 | Window watchdog enable |
| rstOutN | output | 1 | Microcontroller reset, active low |
| drvRelease | output | 1 | Force LIN driver recessive (TX timeout) |
| clearRegs | output | 1 | Clear mode/diagnostic registers (incl. low-slew) |
| wakeSet | output | 1 | Remote-wake flag set strobe |
| tmpShutSet | output | 1 | Temporary-shutdown flag set strobe |
| txToSet | output | 1 | TX-timeout flag set strobe |
| warnSet | output | 1 | Over-temperature warning set strobe |

## Verification
The hardest case to reach is the TX timeout restarting after low-power mode. TX must fall while the block is already in low power, stay low past the whole timeout window, and then stay low through the EN-driven exit back to normal. The bench does this in one long sequence with the timing parameters shrunk. It then checks that the release comes exactly one full window after the return to normal. Simultaneous events, such as a shutdown write in the same cycle as an EN fall, or requests while VCC holds reset low, are driven on purpose. A behavioural model checks every cycle alongside them.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT    = 3'd0,
    M_NORMAL  = 3'd1,
    M_ARM     = 3'd2,
    M_ENTER   = 3'd3,
    M_LOWPWR  = 3'd4,
    M_EXIT    = 3'd5,
    M_TMPSHUT = 3'd6,
    M_THERMAL = 3'd7
  } modeT;

  typedef struct packed {
    logic seqClear;
    logic txArm;
    logic wdArm;
    logic brownOut;
  } ctlT;
endpackage

// File: rtl/lin_mode_seq.sv
module lin_mode_seq
  import lin_mode_pkg::*;
#(
  parameter int TRIG_TICKS    = 5,
  parameter int ENTER_TICKS   = 6,
  parameter int EXIT_TICKS    = 4,
  parameter int WAKE_TICKS    = 13,
  parameter int TMPSHUT_TICKS = 16384,
  parameter bit SLEEP_OPT     = 1'b0,
  parameter int SEQ_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyLow,
  input  logic             hotShut,
  input  logic             warnTemp,
  input  logic             enPin,
  input  logic             txPin,
  input  logic             linDom,
  input  logic             tmpShutWr,
  input  logic             rstOutN,
  input  logic [SEQ_W-1:0] seqCnt,
  output modeT             mode,
  output ctlT              ctl,
  output logic             regEn,
  output logic             xcvrEn,
  output logic             wdEn,
  output logic             clearRegs,
  output logic             wakeSet,
  output logic             tmpShutSet,
  output logic             warnSet
);
  localparam logic [SEQ_W-1:0] TRIG_LIM  = SEQ_W'(TRIG_TICKS);
  localparam logic [SEQ_W-1:0] ENTER_LIM = SEQ_W'(ENTER_TICKS);
  localparam logic [SEQ_W-1:0] EXIT_LIM  = SEQ_W'(EXIT_TICKS);
  localparam logic [SEQ_W-1:0] WAKE_LIM  = SEQ_W'(WAKE_TICKS);
  localparam logic [SEQ_W-1:0] TS_LIM    = SEQ_W'(TMPSHUT_TICKS);

  modeT nxt;
  logic enQ, warnQ;
  logic enRise, enFall, wakeHit, tsHit, activeMode;

  assign enRise = enPin & ~enQ;
  assign enFall = ~enPin & enQ;

  always_comb begin
    nxt     = mode;
    wakeHit = 1'b0;
    tsHit   = 1'b0;
    if (supplyLow) begin
      nxt = M_INIT;
    end else if (hotShut) begin
      nxt = M_THERMAL;
    end else begin
      unique case (mode)
        M_INIT:    nxt = M_NORMAL;
        M_THERMAL: nxt = M_INIT;
        M_NORMAL: begin
          if (rstOutN) begin
            if (tmpShutWr) begin
              nxt   = M_TMPSHUT;
              tsHit = 1'b1;
            end else if (enFall && txPin) begin
              nxt = M_ARM;
            end
          end
        end
        M_ARM: begin
          if (!rstOutN) begin
            nxt = M_NORMAL;
          end else if (tmpShutWr) begin
            nxt   = M_TMPSHUT;
            tsHit = 1'b1;
          end else if (enPin || !txPin) begin
            nxt = M_NORMAL;
          end else if (seqCnt >= TRIG_LIM) begin
            nxt = M_ENTER;
          end
        end
        M_ENTER:   if (seqCnt >= ENTER_LIM) nxt = M_LOWPWR;
        M_LOWPWR: begin
          if (enRise) begin
            nxt = M_EXIT;
          end else if (linDom && seqCnt >= WAKE_LIM) begin
            nxt     = M_EXIT;
            wakeHit = 1'b1;
          end
        end
        M_EXIT:    if (seqCnt >= EXIT_LIM) nxt = M_NORMAL;
        M_TMPSHUT: if (seqCnt >= TS_LIM) nxt = M_NORMAL;
        default:   nxt = M_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= M_INIT;
      enQ        <= 1'b0;
      warnQ      <= 1'b0;
      wakeSet    <= 1'b0;
      tmpShutSet <= 1'b0;
      warnSet    <= 1'b0;
    end else begin
      mode       <= nxt;
      enQ        <= enPin;
      warnQ      <= warnTemp;
      wakeSet    <= wakeHit;
      tmpShutSet <= tsHit;
      warnSet    <= warnTemp & ~warnQ & ~supplyLow;
    end
  end

  assign activeMode = (mode == M_NORMAL) || (mode == M_ARM) || (mode == M_ENTER);
  assign xcvrEn     = activeMode;
  assign wdEn       = activeMode & rstOutN;
  assign clearRegs  = (mode == M_INIT);

  generate
    if (SLEEP_OPT) begin : g_sleep
      assign regEn = !((mode == M_INIT) || (mode == M_TMPSHUT) ||
                       (mode == M_THERMAL) || (mode == M_LOWPWR));
    end else begin : g_standby
      assign regEn = !((mode == M_INIT) || (mode == M_TMPSHUT) ||
                       (mode == M_THERMAL));
    end
  endgenerate

  assign ctl.seqClear = (nxt != mode) || (mode == M_NORMAL) ||
                        ((mode == M_LOWPWR) && !linDom);
  assign ctl.txArm    = (mode == M_NORMAL);
  assign ctl.wdArm    = wdEn;
  assign ctl.brownOut = supplyLow;
endmodule

// File: rtl/lin_mode_timers.sv
module lin_mode_timers
  import lin_mode_pkg::*;
#(
  parameter int TXTO_TICKS  = 131072,
  parameter int RES_TICKS   = 1024,
  parameter int SPIKE_TICKS = 1,
  parameter int SEQ_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  ctlT              ctl,
  input  logic             txPin,
  input  logic             vccLow,
  input  logic             wdFault,
  output logic [SEQ_W-1:0] seqCnt,
  output logic             rstOutN,
  output logic             drvRelease,
  output logic             txToSet
);
  localparam int TX_W  = $clog2(TXTO_TICKS + 1) + 1;
  localparam int RC_MAX = (RES_TICKS > SPIKE_TICKS) ? RES_TICKS : SPIKE_TICKS;
  localparam int RC_W  = $clog2(RC_MAX + 1) + 1;
  localparam logic [TX_W-1:0] TX_LIM    = TX_W'(TXTO_TICKS);
  localparam logic [RC_W-1:0] RES_LIM   = RC_W'(RES_TICKS);
  localparam logic [RC_W-1:0] SPIKE_LIM = RC_W'(SPIKE_TICKS);

  logic [TX_W-1:0] txCnt;
  logic [RC_W-1:0] rc;
  logic            relNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           seqCnt <= '0;
    else if (ctl.seqClear)               seqCnt <= '0;
    else if (tick && (seqCnt != '1))     seqCnt <= seqCnt + 1'b1;
  end

  assign relNext = ctl.txArm && !txPin && (drvRelease || (txCnt >= TX_LIM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt      <= '0;
      drvRelease <= 1'b0;
      txToSet    <= 1'b0;
    end else begin
      if (!ctl.txArm || txPin)             txCnt <= '0;
      else if (tick && (txCnt < TX_LIM))   txCnt <= txCnt + 1'b1;
      drvRelease <= relNext;
      txToSet    <= relNext & ~drvRelease;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstOutN <= 1'b0;
      rc      <= '0;
    end else if (ctl.brownOut) begin
      rstOutN <= 1'b0;
      rc      <= '0;
    end else if (rstOutN) begin
      if (ctl.wdArm && wdFault) begin
        rstOutN <= 1'b0;
        rc      <= '0;
      end else if (!vccLow) begin
        rc <= '0;
      end else if (rc >= SPIKE_LIM) begin
        rstOutN <= 1'b0;
        rc      <= '0;
      end else if (tick) begin
        rc <= rc + 1'b1;
      end
    end else begin
      if (vccLow) begin
        rc <= '0;
      end else if (rc >= RES_LIM) begin
        rstOutN <= 1'b1;
        rc      <= '0;
      end else if (tick) begin
        rc <= rc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int TRIG_TICKS    = 5,
  parameter int ENTER_TICKS   = 6,
  parameter int EXIT_TICKS    = 4,
  parameter int WAKE_TICKS    = 13,
  parameter int TMPSHUT_TICKS = 16384,
  parameter int TXTO_TICKS    = 131072,
  parameter int RES_TICKS     = 1024,
  parameter int SPIKE_TICKS   = 1,
  parameter bit SLEEP_OPT     = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       supplyLow,
  input  logic       hotShut,
  input  logic       warnTemp,
  input  logic       vccLow,
  input  logic       enPin,
  input  logic       txPin,
  input  logic       linDom,
  input  logic       tmpShutWr,
  input  logic       wdFault,
  output logic [2:0] modeOut,
  output logic       regEn,
  output logic       xcvrEn,
  output logic       wdEn,
  output logic       rstOutN,
  output logic       drvRelease,
  output logic       clearRegs,
  output logic       wakeSet,
  output logic       tmpShutSet,
  output logic       txToSet,
  output logic       warnSet
);
  localparam int MAX_A   = (TRIG_TICKS > ENTER_TICKS) ? TRIG_TICKS : ENTER_TICKS;
  localparam int MAX_B   = (EXIT_TICKS > WAKE_TICKS) ? EXIT_TICKS : WAKE_TICKS;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int SEQ_MAX = (MAX_AB > TMPSHUT_TICKS) ? MAX_AB : TMPSHUT_TICKS;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1) + 1;

  modeT             mode;
  ctlT              ctl;
  logic [SEQ_W-1:0] seqCnt;

  lin_mode_seq #(
    .TRIG_TICKS(TRIG_TICKS), .ENTER_TICKS(ENTER_TICKS), .EXIT_TICKS(EXIT_TICKS),
    .WAKE_TICKS(WAKE_TICKS), .TMPSHUT_TICKS(TMPSHUT_TICKS),
    .SLEEP_OPT(SLEEP_OPT), .SEQ_W(SEQ_W)
  ) u_seq (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .hotShut(hotShut),
    .warnTemp(warnTemp), .enPin(enPin), .txPin(txPin), .linDom(linDom),
    .tmpShutWr(tmpShutWr), .rstOutN(rstOutN), .seqCnt(seqCnt),
    .mode(mode), .ctl(ctl), .regEn(regEn), .xcvrEn(xcvrEn), .wdEn(wdEn),
    .clearRegs(clearRegs), .wakeSet(wakeSet), .tmpShutSet(tmpShutSet),
    .warnSet(warnSet)
  );

  lin_mode_timers #(
    .TXTO_TICKS(TXTO_TICKS), .RES_TICKS(RES_TICKS),
    .SPIKE_TICKS(SPIKE_TICKS), .SEQ_W(SEQ_W)
  ) u_tmr (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .txPin(txPin),
    .vccLow(vccLow), .wdFault(wdFault), .seqCnt(seqCnt), .rstOutN(rstOutN),
    .drvRelease(drvRelease), .txToSet(txToSet)
  );

  assign modeOut = mode;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       supplyLow,
  input logic       hotShut,
  input logic       txPin,
  input logic [2:0] modeOut,
  input logic       regEn,
  input logic       xcvrEn,
  input logic       wdEn,
  input logic       rstOutN,
  input logic       drvRelease,
  input logic       clearRegs,
  input logic       wakeSet,
  input logic       txToSet
);
  p_brownout_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> (modeOut == 3'd0 && !rstOutN && clearRegs));

  p_thermal_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hotShut && !supplyLow) |=> (modeOut == 3'd7 && !regEn && !xcvrEn && !wdEn));

  p_tx_high_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    txPin |=> !drvRelease);

  p_strobe_with_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    txToSet |-> drvRelease);

  p_no_wake_in_tmpshut_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 3'd6) |=> !wakeSet);

  p_hold_under_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 3'd1 && !rstOutN && !supplyLow && !hotShut) |=> (modeOut == 3'd1));

  p_no_release_off_normal_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 3'd1) |=> !drvRelease);
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .hotShut(hotShut),
  .txPin(txPin), .modeOut(modeOut), .regEn(regEn), .xcvrEn(xcvrEn),
  .wdEn(wdEn), .rstOutN(rstOutN), .drvRelease(drvRelease),
  .clearRegs(clearRegs), .wakeSet(wakeSet), .txToSet(txToSet)
);

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;
  localparam int TRIG = 3, ENT = 6, EXT = 4, WAKE = 5, TS = 20;
  localparam int TXTO = 30, RES = 8, SPIKE = 2, TICKDIV = 4;

  logic clk = 0, rstN = 0, tick = 0;
  logic supplyLow = 0, hotShut = 0, warnTemp = 0, vccLow = 0;
  logic enPin = 1, txPin = 1, linDom = 0, tmpShutWr = 0, wdFault = 0;
  logic [2:0] modeOut;
  logic regEn, xcvrEn, wdEn, rstOutN, drvRelease, clearRegs;
  logic wakeSet, tmpShutSet, txToSet, warnSet;

  int tests = 0, fails = 0, cyc = 0, tickCnt = 0;
  int wakeSeen = 0, tsSeen = 0, txToSeen = 0, warnSeen = 0;

  always #5 clk = ~clk;

  lin_mode_ctrl #(
    .TRIG_TICKS(TRIG), .ENTER_TICKS(ENT), .EXIT_TICKS(EXT), .WAKE_TICKS(WAKE),
    .TMPSHUT_TICKS(TS), .TXTO_TICKS(TXTO), .RES_TICKS(RES),
    .SPIKE_TICKS(SPIKE), .SLEEP_OPT(1'b0)
  ) u_dut (.*);

  always @(negedge clk) begin
    tickCnt++;
    tick <= (tickCnt % TICKDIV == 0);
  end

  // behavioural reference
  int mMode, mSeq, mTx, mRc;
  bit mRel, mRst, mEnQ, mWarnQ, mWake, mTs, mTxTo, mWarn;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mSeq = 0; mTx = 0; mRc = 0; mRel = 0; mRst = 0;
      mEnQ = 0; mWarnQ = 0; mWake = 0; mTs = 0; mTxTo = 0; mWarn = 0;
    end else begin
      int nx; bit wk, tsh, rel, clr;
      nx = mMode; wk = 0; tsh = 0;
      if (supplyLow) nx = 0;
      else if (hotShut) nx = 7;
      else case (mMode)
        0: nx = 1;
        7: nx = 0;
        1: if (mRst) begin
             if (tmpShutWr) begin nx = 6; tsh = 1; end
             else if (!enPin && mEnQ && txPin) nx = 2;
           end
        2: if (!mRst) nx = 1;
           else if (tmpShutWr) begin nx = 6; tsh = 1; end
           else if (enPin || !txPin) nx = 1;
           else if (mSeq >= TRIG) nx = 3;
        3: if (mSeq >= ENT) nx = 4;
        4: if (enPin && !mEnQ) nx = 5;
           else if (linDom && mSeq >= WAKE) begin nx = 5; wk = 1; end
        5: if (mSeq >= EXT) nx = 1;
        6: if (mSeq >= TS) nx = 1;
        default: nx = 0;
      endcase
      clr = (nx != mMode) || (mMode == 1) || (mMode == 4 && !linDom);
      rel = (mMode == 1) && !txPin && (mRel || mTx >= TXTO);
      // reset output
      if (supplyLow) begin mRst = 0; mRc = 0; end
      else if (mRst) begin
        if (wdFault && (mMode >= 1 && mMode <= 3)) begin mRst = 0; mRc = 0; end
        else if (!vccLow) mRc = 0;
        else if (mRc >= SPIKE) begin mRst = 0; mRc = 0; end
        else if (tick) mRc++;
      end else begin
        if (vccLow) mRc = 0;
        else if (mRc >= RES) begin mRst = 1; mRc = 0; end
        else if (tick) mRc++;
      end
      if (mMode != 1 || txPin) mTx = 0; else if (tick && mTx < TXTO) mTx++;
      mTxTo = rel && !mRel;
      mRel = rel;
      if (clr) mSeq = 0; else if (tick) mSeq++;
      mWarn = warnTemp && !mWarnQ && !supplyLow;
      mWarnQ = warnTemp; mEnQ = enPin; mWake = wk; mTs = tsh; mMode = nx;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rstN && cyc > 2) begin
      bit act, mReg, mXc, mWd;
      act  = (mMode >= 1 && mMode <= 3);
      mXc  = act;
      mWd  = act && mRst;
      mReg = !(mMode == 0 || mMode == 6 || mMode == 7);
      check(modeOut == mMode, "R2 mode", modeOut, mMode);
      check(rstOutN == mRst, "R8 rstOutN", rstOutN, mRst);
      check(drvRelease == mRel, "R7 drvRelease", drvRelease, mRel);
      check(txToSet == mTxTo, "R7 txToSet", txToSet, mTxTo);
      check(wakeSet == mWake, "R3 wakeSet", wakeSet, mWake);
      check(tmpShutSet == mTs, "R4 tmpShutSet", tmpShutSet, mTs);
      check(warnSet == mWarn, "R9 warnSet", warnSet, mWarn);
      check(regEn == mReg, "R12 regEn", regEn, mReg);
      check(xcvrEn == mXc, "R12 xcvrEn", xcvrEn, mXc);
      check(wdEn == mWd, "R12 wdEn", wdEn, mWd);
      check(clearRegs == (mMode == 0), "R1 clearRegs", clearRegs, mMode == 0);
    end
    if (wakeSet) wakeSeen++;
    if (tmpShutSet) tsSeen++;
    if (txToSet) txToSeen++;
    if (warnSet) warnSeen++;
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitc(3);
    check(modeOut == 0 && !rstOutN && clearRegs, "R1 reset state", modeOut, 0);
    rstN = 1;
    waitc(60);
    check(modeOut == 1, "R1 normal after init", modeOut, 1);
    check(rstOutN == 1, "R8 reset released", rstOutN, 1);

    // R2 standby entry
    enPin = 0;
    waitc(120);
    check(modeOut == 4, "R2 in low power", modeOut, 4);
    check(regEn == 1 && xcvrEn == 0, "R12 standby enables", {regEn, xcvrEn}, 2);

    // R3 short dominant ignored, then a real wake
    linDom = 1; waitc(8); linDom = 0; waitc(40);
    check(modeOut == 4, "R3 short dominant ignored", modeOut, 4);
    linDom = 1; waitc(40); linDom = 0;
    check(wakeSeen == 1, "R3 wake strobe", wakeSeen, 1);
    waitc(40);
    check(modeOut == 1, "R6 back to normal after exit", modeOut, 1);

    // R2 arm abort by TX low, then R7 timeout
    enPin = 1; waitc(2); enPin = 0; waitc(2); txPin = 0; waitc(3);
    check(modeOut == 1, "R2 arm aborted", modeOut, 1);
    waitc(140);
    check(drvRelease == 1 && txToSeen == 1, "R7 release after timeout", drvRelease, 1);
    txPin = 1; waitc(2);
    check(drvRelease == 0, "R7 release drops with TX high", drvRelease, 0);

    // R11 TX low in low power, then EN rise (R6)
    enPin = 1; waitc(2); enPin = 0; waitc(120);
    check(modeOut == 4, "R11 low power reached", modeOut, 4);
    txPin = 0; waitc(160);
    check(drvRelease == 0 && txToSeen == 1, "R11 no release off normal", drvRelease, 0);
    enPin = 1; waitc(30);
    check(modeOut == 1, "R6 EN rise exit", modeOut, 1);
    check(drvRelease == 0, "R11 count restarted", drvRelease, 0);
    waitc(130);
    check(drvRelease == 1 && txToSeen == 2, "R11 release after full window", txToSeen, 2);
    txPin = 1; waitc(4);

    // R4 temporary shutdown with LIN activity ignored
    tmpShutWr = 1; waitc(1); tmpShutWr = 0; linDom = 1; waitc(2);
    check(modeOut == 6 && regEn == 0 && tsSeen == 1, "R4 tmpshut entered", modeOut, 6);
    waitc(90); linDom = 0;
    check(modeOut == 1 && wakeSeen == 1, "R4 timed return, no wake", modeOut, 1);

    // R8 spike ignored, long low asserts, R10 requests blocked
    vccLow = 1; waitc(4); vccLow = 0; waitc(10);
    check(rstOutN == 1, "R8 spike filtered", rstOutN, 1);
    vccLow = 1; waitc(20);
    check(rstOutN == 0, "R8 reset asserted", rstOutN, 0);
    tmpShutWr = 1; waitc(1); tmpShutWr = 0; enPin = 0; waitc(6);
    check(modeOut == 1 && tsSeen == 1, "R10 blocked under reset", modeOut, 1);
    enPin = 1; vccLow = 0; waitc(50);
    check(rstOutN == 1, "R8 release after good VCC", rstOutN, 1);

    // R10 same-cycle tmpshut and EN fall
    tmpShutWr = 1; enPin = 0; waitc(1); tmpShutWr = 0; waitc(2);
    check(modeOut == 6, "R10 tmpshut wins", modeOut, 6);
    enPin = 1; waitc(90);

    // R13 watchdog fault
    wdFault = 1; waitc(1); wdFault = 0; waitc(1);
    check(rstOutN == 0, "R13 fault asserts reset", rstOutN, 0);
    waitc(40);
    check(rstOutN == 1, "R13 reset released", rstOutN, 1);

    // R9 warning
    warnTemp = 1; waitc(3);
    check(warnSeen == 1 && modeOut == 1, "R9 warning no mode change", warnSeen, 1);
    warnTemp = 0;

    // R5 thermal from low power
    enPin = 0; waitc(120);
    hotShut = 1; waitc(3);
    check(modeOut == 7 && regEn == 0 && xcvrEn == 0, "R5 thermal", modeOut, 7);
    hotShut = 0; waitc(1);
    check(modeOut == 0 && clearRegs == 1, "R5 init after thermal", modeOut, 0);
    waitc(2);
    check(modeOut == 1, "R5 normal after init", modeOut, 1);

    // R1 brown-out during tmpshut
    enPin = 1; waitc(50);
    tmpShutWr = 1; waitc(1); tmpShutWr = 0; waitc(3);
    supplyLow = 1; waitc(2);
    check(modeOut == 0 && rstOutN == 0, "R1 brown-out", modeOut, 0);
    supplyLow = 0; waitc(2);
    check(modeOut == 1, "R1 recovers to normal", modeOut, 1);
    waitc(50);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule